// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler with Overhead-Window Reference

This block scrambles a byte-parallel SONET transmit stream with a frame-synchronous sequence. A strobe marks the first framing byte of each frame. The block then lets the framing and trace bytes at the head of the frame pass unchanged. There are three groups of N bytes each, 3N bytes in all. N is 3 for the STS-3c rate and 12 for the STS-12c rate.

On the first byte after that span, the block loads all ones into a seven-stage generator for x^7 + x^6 + 1. From then until the next frame start, it XORs eight sequence bits onto every valid byte.

The same span also drives a reference output. It is high while unscrambled framing bytes are being emitted and low for the rest of the frame, so it pulses once per frame at 8 kHz. Every output is registered, one cycle after the input byte that produced it.

Top module: `sonet_frame_scrambler`

## Requirements
- R1: During and straight after reset, out_valid, ref8k and out_byte are all zero.
- R2: Before the first accepted frame start after reset, every valid byte leaves unchanged and ref8k stays low.
- R3: out_valid equals in_valid of the previous cycle. In a cycle with in_valid low, the next out_byte and ref8k hold their previous values.
- R4: frame_start together with in_valid marks the first framing byte. That byte and the next 3N-1 valid bytes leave unchanged. N is 3 when rate_sel is 0 and 12 when rate_sel is 1.
- R5: The valid byte after the unscrambled span is XORed with eight sequence bits taken from an all-ones state. The first sequence bit goes to bit 7. With zero data, that byte and the next valid one come out as 0xFE and 0x04.
- R6: Later valid bytes are XORed with the continuing sequence until the next frame start. Each stage shift emits the oldest stage and feeds in the XOR of stages 7 and 6. Cycles with in_valid low do not advance the sequence.
- R7: ref8k rises with the output of the first framing byte. It falls with the output of the first scrambled byte, and is low at all other times.
- R8: frame_start with in_valid low has no effect.
- R9: rate_sel is taken only with an accepted frame start. An accepted frame start at any point, including inside the unscrambled span or on the byte that would be reseeded, restarts the span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Transmit byte in |
| in_valid | input | 1 | in_byte holds a byte this cycle |
| frame_start | input | 1 | Current byte is the first framing byte |
| rate_sel | input | 1 | 0: three bytes per framing group, 1: twelve |
| out_byte | output | 8 | Scrambled or passed byte |
| out_valid | output | 1 | out_byte is new this cycle |
| ref8k | output | 1 | High while unscrambled framing bytes are emitted |

## Verification
Two events can land on the same byte: a new frame start and the reseed of the previous frame's span. The bench places a frame start exactly on the byte where the count reaches 3N. It expects the restart to win: the byte passes unchanged, ref8k stays high, and reseeding moves 3N bytes later. The same applies to frame starts inside the span and to rate changes during it. A bit-serial model in the bench judges every cycle, and the 0xFE/0x04 pair is checked on its own after each reseed that carries zero data.

// File: rtl/scr_pkg.sv
package scr_pkg;
    // Position of the tracker inside the frame
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no frame start seen since reset
        PH_OH   = 2'd1,   // inside the unscrambled framing span
        PH_PAY  = 2'd2    // scrambling until the next frame start
    } phase_e;
endpackage

// File: rtl/scr_key_gen.sv
module scr_key_gen #(
    parameter int DW = 8,
    parameter int SW = 7
) (
    input  logic [SW-1:0] state_i,
    output logic [DW-1:0] key_o,
    output logic [SW-1:0] state_o
);
    // One stage of x^7 + x^6 + 1 per bit, first bit lands in the MSB
    logic [SW-1:0] chain [0:DW];

    assign chain[0] = state_i;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign key_o[DW-1-g] = chain[g][SW-1];
        assign chain[g+1]    = {chain[g][SW-2:0], chain[g][SW-1] ^ chain[g][SW-2]};
    end

    assign state_o = chain[DW];
endmodule

// File: rtl/scr_oh_tracker.sv
module scr_oh_tracker
    import scr_pkg::*;
#(
    parameter int N_LO = 3,
    parameter int N_HI = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic start_i,
    input  logic wide_i,
    output logic bypass_o,
    output logic reseed_o,
    output logic payload_o
);
    localparam int LEN_LO = 3 * N_LO;
    localparam int LEN_HI = 3 * N_HI;
    localparam int CW     = $clog2(LEN_HI + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          wide;
    } trk_t;

    trk_t          st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d      = st_q;
        bypass_o  = 1'b0;
        reseed_o  = 1'b0;
        payload_o = 1'b0;
        lim       = st_q.wide ? CW'(LEN_HI) : CW'(LEN_LO);
        if (valid_i) begin
            if (start_i) begin
                st_d.phase = PH_OH;
                st_d.cnt   = CW'(1);
                st_d.wide  = wide_i;
                bypass_o   = 1'b1;
            end else begin
                case (st_q.phase)
                    PH_OH: begin
                        if (st_q.cnt == lim) begin
                            reseed_o   = 1'b1;
                            payload_o  = 1'b1;
                            st_d.phase = PH_PAY;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                            bypass_o = 1'b1;
                        end
                    end
                    PH_PAY:  payload_o = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, wide: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    oh_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_OH |-> (st_q.cnt >= CW'(1) && st_q.cnt <= lim));

    // R4
    no_early_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && start_i |=> !reseed_o);

    // R5
    reseed_enters_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_o |=> st_q.phase == PH_PAY);
endmodule

// File: rtl/sonet_frame_scrambler.sv
module sonet_frame_scrambler #(
    parameter int DW   = 8,
    parameter int N_LO = 3,
    parameter int N_HI = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_byte,
    input  logic          in_valid,
    input  logic          frame_start,
    input  logic          rate_sel,
    output logic [DW-1:0] out_byte,
    output logic          out_valid,
    output logic          ref8k
);
    localparam int SW = 7;

    typedef struct packed {
        logic [SW-1:0] lfsr;
        logic [DW-1:0] data;
        logic          vld;
        logic          refp;
    } out_t;

    out_t          r_d, r_q;
    logic          bypass, reseed, payload;
    logic [SW-1:0] seed_state, next_state;
    logic [DW-1:0] key;

    scr_oh_tracker #(.N_LO(N_LO), .N_HI(N_HI)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (in_valid),
        .start_i   (frame_start),
        .wide_i    (rate_sel),
        .bypass_o  (bypass),
        .reseed_o  (reseed),
        .payload_o (payload)
    );

    scr_key_gen #(.DW(DW), .SW(SW)) u_key (
        .state_i (seed_state),
        .key_o   (key),
        .state_o (next_state)
    );

    always_comb begin
        seed_state = reseed ? '1 : r_q.lfsr;
        r_d        = r_q;
        r_d.vld    = in_valid;
        if (in_valid) begin
            r_d.refp = bypass;
            if (payload) begin
                r_d.data = in_byte ^ key;
                r_d.lfsr = next_state;
            end else begin
                r_d.data = in_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{lfsr: '1, data: '0, vld: 1'b0, refp: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_byte  = r_q.data;
    assign out_valid = r_q.vld;
    assign ref8k     = r_q.refp;

    // R3
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_byte) && $stable(ref8k));

    // R4
    first_a1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && frame_start |=> ref8k && out_byte == $past(in_byte));

    // R6
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != '0);

    // R6
    gap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(r_q.lfsr));

    // R7
    ref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref8k) |-> out_valid && $past(frame_start));

    // R7
    ref_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref8k) |-> out_valid);
endmodule

// File: tb/sonet_frame_scrambler_bench.sv
module sonet_frame_scrambler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_valid = 1'b0;
    logic       frame_start = 1'b0;
    logic       rate_sel = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid;
    logic       ref8k;

    always #10 clk = ~clk;

    sonet_frame_scrambler u_sonet_frame_scrambler (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .frame_start(frame_start), .rate_sel(rate_sel),
        .out_byte(out_byte), .out_valid(out_valid), .ref8k(ref8k)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected outputs for the next compare
    logic [7:0] exp_byte = '0;
    logic       exp_valid = 1'b0;
    logic       exp_ref = 1'b0;
    string      exp_tag = "R1";
    bit         fixed_vld = 0;
    logic [7:0] fixed_val = '0;

    // behavioural model state
    int         m_phase = 0;   // 0 idle, 1 span, 2 scrambling
    int         m_cnt = 0;
    int         m_len = 9;
    bit         m_wide = 0;
    int         since = 99;
    logic [6:0] ms = 7'h7f;

    task automatic next_key(output logic [7:0] k);
        k = '0;
        for (int i = 0; i < 8; i++) begin
            k  = {k[6:0], ms[6]};
            ms = {ms[5:0], ms[6] ^ ms[5]};
        end
    endtask

    task automatic model(input logic v, input logic fs, input logic [7:0] d, input logic rs);
        logic [7:0] k;
        fixed_vld = 0;
        if (!v) begin
            exp_valid = 1'b0;
            exp_tag   = fs ? "R8" : "R3";
        end else begin
            exp_valid = 1'b1;
            if (fs) begin
                exp_tag  = (m_phase == 0) ? "R4" : "R9";
                m_wide   = rs;
                m_len    = rs ? 36 : 9;
                m_cnt    = 1;
                m_phase  = 1;
                exp_byte = d;
                exp_ref  = 1'b1;
            end else if (m_phase == 1) begin
                if (m_cnt == m_len) begin
                    ms = 7'h7f;
                    next_key(k);
                    exp_byte = d ^ k;
                    exp_ref  = 1'b0;
                    exp_tag  = "R5 R7";
                    m_phase  = 2;
                    since    = 0;
                end else begin
                    m_cnt++;
                    exp_byte = d;
                    exp_ref  = 1'b1;
                    exp_tag  = (rs != m_wide) ? "R9" : "R4";
                end
            end else if (m_phase == 2) begin
                next_key(k);
                exp_byte = d ^ k;
                exp_ref  = 1'b0;
                exp_tag  = "R6";
            end else begin
                exp_byte = d;
                exp_ref  = 1'b0;
                exp_tag  = "R2";
            end
            if (m_phase == 2 && since < 2) begin
                if (d == 8'h00) begin
                    fixed_vld = 1;
                    fixed_val = (since == 0) ? 8'hFE : 8'h04;
                end
                since++;
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid || out_byte !== exp_byte || ref8k !== exp_ref) begin
            fails++;
            $display("FAIL %s: actual v=%b byte=%h ref=%b, expected v=%b byte=%h ref=%b",
                     exp_tag, out_valid, out_byte, ref8k, exp_valid, exp_byte, exp_ref);
        end
        if (fixed_vld) begin
            checks++;
            if (out_byte !== fixed_val) begin
                fails++;
                $display("FAIL R5: actual byte=%h, expected %h", out_byte, fixed_val);
            end
        end
    endtask

    task automatic step(input logic v, input logic fs, input logic [7:0] d, input logic rs);
        @(negedge clk);
        compare();
        in_valid    = v;
        frame_start = fs;
        in_byte     = d;
        rate_sel    = rs;
        model(v, fs, d, rs);
    endtask

    task automatic run_bytes(input int n, input int gap_every, input logic rs);
        for (int i = 1; i <= n; i++) begin
            if (gap_every > 0 && i % gap_every == 0)
                step(1'b0, 1'b0, 8'($urandom), rs);
            step(1'b1, 1'b0, 8'($urandom), rs);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || ref8k !== 1'b0 || out_byte !== 8'h00) begin
            fails++;
            $display("FAIL R1: actual v=%b ref=%b byte=%h, expected 0 0 00", out_valid, ref8k, out_byte);
        end
        rst_n = 1'b1;

        // R2 idle pass-through
        run_bytes(6, 4, 1'b0);

        // narrow frame with gaps, then zero bytes at reseed (R4 R5 R6 R3)
        step(1'b1, 1'b1, 8'hF6, 1'b0);
        run_bytes(8, 3, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'h55, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        run_bytes(60, 5, 1'b0);

        // R8 strobe without valid
        step(1'b0, 1'b1, 8'hAA, 1'b1);
        run_bytes(20, 0, 1'b0);

        // wide frame, rate_sel dropped inside the span (R9)
        step(1'b1, 1'b1, 8'hF6, 1'b1);
        run_bytes(35, 7, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        run_bytes(50, 6, 1'b0);

        // restart inside the span (R9)
        step(1'b1, 1'b1, 8'hF6, 1'b0);
        run_bytes(4, 0, 1'b0);
        step(1'b1, 1'b1, 8'hF6, 1'b0);
        run_bytes(8, 0, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        run_bytes(20, 0, 1'b0);

        // frame start on the byte that would be reseeded (R9)
        step(1'b1, 1'b1, 8'hF6, 1'b0);
        run_bytes(8, 0, 1'b0);
        step(1'b1, 1'b1, 8'h28, 1'b0);
        run_bytes(8, 0, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        run_bytes(10, 0, 1'b0);

        // long wide frame, sequence wraps many times (R6)
        step(1'b1, 1'b1, 8'hF6, 1'b1);
        run_bytes(3000, 11, 1'b1);

        step(1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        finish_run();
    end
endmodule